// File: doc/BRIEF.md
# Floating-point status register update unit

This block keeps the 32-bit floating-point status and control word and folds in the outcome of each floating-point instruction as it completes. When an instruction finishes, the execution pipeline raises a completion strobe together with an operation class and the instruction's new exception flags, rounded and inexact flags and result-class code. The block merges these into the word, derives the summary bits from the result and forces the reserved bit low. The arithmetic, the rounding and any interrupt are handled elsewhere.

Two copies are held. The working copy follows every change, including the early clearing of the rounded/inexact flags when an integer-to-float conversion starts. The committed copy changes only on a completion. A flush reloads the working copy from the committed copy. No input stream applies back-pressure: the strobes are plain control pins and an update is taken on every cycle the completion strobe is high.

Word layout, bit 0 least significant: 31 FX sticky summary, 30 FEX enabled summary, 29 VX invalid summary, 28 overflow, 27 underflow, 26 zero-divide, 25 inexact, 24 signalling-NaN, 23 inf-minus-inf, 22 inf-div-inf, 21 zero-div-zero, 20 inf-times-zero, 19 invalid compare, 18 FR rounded, 17 FI inexact, 16:12 result class, 11 reserved, 10 software invalid, 9 invalid square root, 8 invalid integer convert, 7 invalid enable, 6 overflow enable, 5 underflow enable, 4 zero-divide enable, 3 inexact enable, 2 non-IEEE mode, 1:0 rounding mode.

Top module: `fpsr_update`

## Requirements
- R1: After a synchronous active-high reset both copies and the condition output are zero.
- R2: For class 0 (arithmetic) a completion ORs the flags of `exc_i` into the word and loads FR, FI and the result-class field from the inputs; both copies hold the new value, class field included, from the edge that samples the strobe. `exc_i` bits: 3 overflow, 2 underflow, 1 zero-divide, 0 inexact, 12 down to 4 signalling-NaN, inf-minus-inf, inf-div-inf, zero-div-zero, inf-times-zero, invalid compare, software, square root, integer convert.
- R3: With `trivial_i` high, an arithmetic or convert-to-integer completion clears FR and FI whatever `fr_i` and `fi_i` hold.
- R4: FX is set when an individual exception bit (bits 28 to 19 except 18..., namely 28..25, 24..19, 10..8) goes from 0 to 1; an exception that is already set leaves FX unchanged.
- R5: VX is the OR of the nine invalid bits and FEX the OR of each of overflow, underflow, zero-divide, inexact and VX ANDed with its enable; both are recomputed after every update.
- R6: Bit 11 always reads zero, and a bit-write to bit 11, 29 or 30 leaves the word unchanged.
- R7: Class 4 (bit-write) writes `bit_val_i` into bit `bit_idx_i`; setting an exception bit this way also sets FX.
- R8: Class 5 (field read) puts field `fld_i` (bits 31-4k down to 28-4k) on `cr_o` in the next cycle, with the reserved bit read as zero, and clears FX and the individual exception bits in that field.
- R9: Class 1 (select/move) leaves the word unchanged whatever the flag inputs hold.
- R10: Class 3 (round to integer) clears FR and FI, loads the result class and never sets the inexact bit.
- R11: Class 2 (convert to integer) ORs in the exceptions, loads FR and FI, and writes zero into the result-class field.
- R12: `cvt_start_i` without a completion clears FR and FI in the working copy only.
- R13: `flush_i` reloads the working copy from the committed copy at the next edge and overrides a completion in the same cycle; a completion followed by a flush keeps the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| done_i | input | 1 | Instruction completion strobe |
| flush_i | input | 1 | Discard working changes |
| cvt_start_i | input | 1 | Integer-to-float conversion begins |
| op_i | input | 3 | Operation class |
| exc_i | input | 13 | New exception flags |
| fr_i | input | 1 | New rounded flag |
| fi_i | input | 1 | New inexact flag |
| fprf_i | input | 5 | New result-class code |
| trivial_i | input | 1 | Result needed no computation |
| bit_idx_i | input | 5 | Bit index for class 4 |
| bit_val_i | input | 1 | Bit value for class 4 |
| fld_i | input | 3 | Field index for class 5 |
| status_o | output | 32 | Committed word |
| work_o | output | 32 | Working word |
| cr_o | output | 4 | Field read result |

## Verification
The bench goes after the edge-versus-level distinction of FX: after a field read clears FX, an arithmetic result re-raising an already set zero-divide flag must leave FX low, which a level-sensitive design would set again. It tries writes to the reserved and summary bits, which a design without protection would let through, and a round-to-integer with the inexact flag high, which a careless design would record. It issues a completion followed one cycle later by a flush; a design that commits the old result class, or commits a cycle late, would lose the update.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned EXC_W  = 13;
  localparam int unsigned CLS_W  = 5;

  localparam int unsigned B_FX   = 31;
  localparam int unsigned B_FEX  = 30;
  localparam int unsigned B_VX   = 29;
  localparam int unsigned B_OX   = 28;
  localparam int unsigned B_UX   = 27;
  localparam int unsigned B_ZX   = 26;
  localparam int unsigned B_XX   = 25;
  localparam int unsigned B_FR   = 18;
  localparam int unsigned B_FI   = 17;
  localparam int unsigned B_CLS  = 12;
  localparam int unsigned B_RSV  = 11;
  localparam int unsigned B_VE   = 7;
  localparam int unsigned B_OE   = 6;
  localparam int unsigned B_UE   = 5;
  localparam int unsigned B_ZE   = 4;
  localparam int unsigned B_XE   = 3;

  localparam logic [WORD_W-1:0] INV_MASK  = 32'h01F8_0700;
  localparam logic [WORD_W-1:0] EXC_MASK  = 32'h1FF8_0700;
  localparam logic [WORD_W-1:0] CLS_MASK  = 32'h0001_F000;

  typedef enum logic [2:0] {
    OPC_ARITH  = 3'd0,
    OPC_MOVE   = 3'd1,
    OPC_CVTINT = 3'd2,
    OPC_RNDINT = 3'd3,
    OPC_SETBIT = 3'd4,
    OPC_GETFLD = 3'd5
  } opc_e;

  function automatic logic [WORD_W-1:0] exc_to_word(input logic [EXC_W-1:0] e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_OX]    = e[3];
    w[B_UX]    = e[2];
    w[B_ZX]    = e[1];
    w[B_XX]    = e[0];
    w[24:19]   = e[12:7];
    w[10:8]    = e[6:4];
    return w;
  endfunction
endpackage

// File: rtl/fpsr_field.sv
module fpsr_field
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        fld_i,
  output logic [3:0]        nib_o,
  output logic [WORD_W-1:0] clr_o
);
  logic [4:0]        lsb;
  logic [WORD_W-1:0] visible;

  always_comb begin
    lsb     = 5'd28 - {fld_i, 2'b00};
    visible = word_i;
    visible[B_RSV] = 1'b0;
    nib_o   = visible[lsb +: 4];
    clr_o   = (32'hF << lsb) & (EXC_MASK | (32'h1 << B_FX));
  end
endmodule

// File: rtl/fpsr_merge.sv
module fpsr_merge
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] cur_i,
  input  logic [2:0]        op_i,
  input  logic [EXC_W-1:0]  exc_i,
  input  logic              fr_i,
  input  logic              fi_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              trivial_i,
  input  logic [4:0]        bit_idx_i,
  input  logic              bit_val_i,
  input  logic [WORD_W-1:0] clr_i,
  output logic [WORD_W-1:0] raw_o
);
  logic [WORD_W-1:0] exc_w;
  logic              guarded;

  always_comb begin
    exc_w   = exc_to_word(exc_i);
    guarded = (bit_idx_i == 5'(B_RSV)) || (bit_idx_i == 5'(B_VX)) ||
              (bit_idx_i == 5'(B_FEX));
    raw_o   = cur_i;
    case (opc_e'(op_i))
      OPC_ARITH, OPC_CVTINT: begin
        raw_o          = cur_i | exc_w;
        raw_o[B_FR]    = fr_i & ~trivial_i;
        raw_o[B_FI]    = fi_i & ~trivial_i;
        raw_o[B_CLS +: CLS_W] = (opc_e'(op_i) == OPC_CVTINT) ? '0 : cls_i;
      end
      OPC_RNDINT: begin
        raw_o          = cur_i | (exc_w & ~(32'h1 << B_XX));
        raw_o[B_FR]    = 1'b0;
        raw_o[B_FI]    = 1'b0;
        raw_o[B_CLS +: CLS_W] = cls_i;
      end
      OPC_SETBIT: begin
        if (!guarded) raw_o[bit_idx_i] = bit_val_i;
      end
      OPC_GETFLD: raw_o = cur_i & ~clr_i;
      default:    raw_o = cur_i;
    endcase
  end
endmodule

// File: rtl/fpsr_summary.sv
module fpsr_summary
  import fpsr_pkg::*;
(
  input  logic [WORD_W-1:0] prev_i,
  input  logic [WORD_W-1:0] raw_i,
  output logic [WORD_W-1:0] final_o
);
  logic vx, fex, rise;

  always_comb begin
    vx   = |(raw_i & INV_MASK);
    fex  = (raw_i[B_OX] & raw_i[B_OE]) | (raw_i[B_UX] & raw_i[B_UE]) |
           (raw_i[B_ZX] & raw_i[B_ZE]) | (raw_i[B_XX] & raw_i[B_XE]) |
           (vx & raw_i[B_VE]);
    rise = |(raw_i & EXC_MASK & ~prev_i);
    final_o         = raw_i;
    final_o[B_VX]   = vx;
    final_o[B_FEX]  = fex;
    final_o[B_FX]   = raw_i[B_FX] | rise;
    final_o[B_RSV]  = 1'b0;
  end
endmodule

// File: rtl/fpsr_update.sv
module fpsr_update
  import fpsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              done_i,
  input  logic              flush_i,
  input  logic              cvt_start_i,
  input  logic [2:0]        op_i,
  input  logic [12:0]       exc_i,
  input  logic              fr_i,
  input  logic              fi_i,
  input  logic [4:0]        fprf_i,
  input  logic              trivial_i,
  input  logic [4:0]        bit_idx_i,
  input  logic              bit_val_i,
  input  logic [2:0]        fld_i,
  output logic [31:0]       status_o,
  output logic [31:0]       work_o,
  output logic [3:0]        cr_o
);
  logic [WORD_W-1:0] work_q, comm_q, clr, raw, nxt;
  logic [3:0]        nib, cr_q;
  logic              take;

  assign take = done_i & ~flush_i;

  fpsr_field u_field (.word_i(work_q), .fld_i(fld_i), .nib_o(nib), .clr_o(clr));

  fpsr_merge u_merge (
    .cur_i(work_q), .op_i(op_i), .exc_i(exc_i), .fr_i(fr_i), .fi_i(fi_i),
    .cls_i(fprf_i), .trivial_i(trivial_i), .bit_idx_i(bit_idx_i),
    .bit_val_i(bit_val_i), .clr_i(clr), .raw_o(raw)
  );

  fpsr_summary u_sum (.prev_i(work_q), .raw_i(raw), .final_o(nxt));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      work_q <= '0;
      comm_q <= '0;
      cr_q   <= '0;
    end else if (flush_i) begin
      work_q <= comm_q;
    end else if (take) begin
      work_q <= nxt;
      comm_q <= nxt;
      if (opc_e'(op_i) == OPC_GETFLD) cr_q <= nib;
    end else if (cvt_start_i) begin
      work_q[B_FR] <= 1'b0;
      work_q[B_FI] <= 1'b0;
    end
  end

  assign status_o = comm_q;
  assign work_o   = work_q;
  assign cr_o     = cr_q;

  a_r6_reserved_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !comm_q[B_RSV] && !work_q[B_RSV]);

  a_r5_vx_matches: assert property (@(posedge clk_i) disable iff (rst_i)
    comm_q[B_VX] == |(comm_q & INV_MASK));

  a_r4_fx_on_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(comm_q & EXC_MASK & ~$past(comm_q))) |-> comm_q[B_FX]);

  a_r9_move_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    (take && opc_e'(op_i) == OPC_MOVE) |=> comm_q == $past(comm_q));

  a_r13_flush_restores: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> work_q == $past(comm_q));

  a_r2_class_committed: assert property (@(posedge clk_i) disable iff (rst_i)
    (take && opc_e'(op_i) == OPC_ARITH) |=>
      (comm_q[B_CLS +: CLS_W] == $past(fprf_i)) && (work_q == comm_q));
endmodule

// File: tb/fpsr_update_test.sv
module fpsr_update_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        done = 0, flush = 0, cvt_start = 0, fr = 0, fi = 0, trivial = 0, bit_val = 0;
  logic [2:0]  op = 0, fld = 0;
  logic [12:0] exc = 0;
  logic [4:0]  fprf = 0, bit_idx = 0;
  logic [31:0] status, work;
  logic [3:0]  cr;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpsr_update uut (
    .clk_i(clk), .rst_i(rst), .done_i(done), .flush_i(flush), .cvt_start_i(cvt_start),
    .op_i(op), .exc_i(exc), .fr_i(fr), .fi_i(fi), .fprf_i(fprf), .trivial_i(trivial),
    .bit_idx_i(bit_idx), .bit_val_i(bit_val), .fld_i(fld),
    .status_o(status), .work_o(work), .cr_o(cr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [12:0] e, input logic r, input logic i,
                       input logic [4:0] c, input logic t);
    @(negedge clk);
    op = o; exc = e; fr = r; fi = i; fprf = c; trivial = t; done = 1;
    @(negedge clk);
    done = 0; exc = 0; trivial = 0;
  endtask

  task automatic setbit(input logic [4:0] idx, input logic v);
    @(negedge clk);
    op = 3'd4; bit_idx = idx; bit_val = v; done = 1;
    @(negedge clk);
    done = 0;
  endtask

  task automatic getfld(input logic [2:0] f);
    @(negedge clk);
    op = 3'd5; fld = f; done = 1;
    @(negedge clk);
    done = 0;
  endtask

  task automatic t_reset();
    check("R1 status", status, 32'h0);
    check("R1 work", work, 32'h0);
    check("R1 cr", {28'h0, cr}, 32'h0);
  endtask

  task automatic t_arith_and_enable();
    issue(3'd0, 13'h002, 1, 0, 5'h04, 0);
    check("R2 status", status, 32'h8404_4000);
    check("R2 work", work, 32'h8404_4000);
    setbit(5'd4, 1);
    check("R5 fex from enable", status, 32'hC404_4010);
  endtask

  task automatic t_edge_vs_level();
    getfld(3'd0);
    check("R8 cr field0", {28'h0, cr}, 32'hC);
    check("R8 clears fx", status, 32'h4404_4010);
    issue(3'd0, 13'h002, 0, 1, 5'h02, 0);
    check("R4 no fx on set flag", status, 32'h4402_2010);
    issue(3'd0, 13'h1000, 1, 1, 5'h11, 1);
    check("R3 R4 R5 trivial snan", status, 32'hE501_1010);
  endtask

  task automatic t_protected_bits();
    setbit(5'd11, 1);
    check("R6 reserved", status, 32'hE501_1010);
    setbit(5'd29, 0);
    check("R6 vx write", status, 32'hE501_1010);
    setbit(5'd30, 0);
    check("R6 fex write", status, 32'hE501_1010);
  endtask

  task automatic t_setbit_fx();
    setbit(5'd31, 0);
    check("R7 clear fx", status, 32'h6501_1010);
    setbit(5'd10, 1);
    check("R7 implicit fx", status, 32'hE501_1410);
    getfld(3'd5);
    check("R8 cr field5", {28'h0, cr}, 32'h4);
    check("R8 clears soft", status, 32'hE501_1010);
  endtask

  task automatic t_move_round_cvt();
    issue(3'd1, 13'h1FFF, 1, 1, 5'h1F, 0);
    check("R9 move", status, 32'hE501_1010);
    issue(3'd0, 13'h000, 1, 1, 5'h08, 0);
    check("R2 fr fi set", status, 32'hE506_8010);
    issue(3'd3, 13'h001, 1, 1, 5'h04, 0);
    check("R10 round", status, 32'hE500_4010);
    issue(3'd2, 13'h011, 1, 0, 5'h1F, 0);
    check("R11 cvt", status, 32'hE704_0110);
  endtask

  task automatic t_start_flush();
    @(negedge clk); cvt_start = 1;
    @(negedge clk); cvt_start = 0;
    check("R12 work", work, 32'hE700_0110);
    check("R12 status", status, 32'hE704_0110);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    check("R13 restore", work, 32'hE704_0110);
    @(negedge clk);
    op = 3'd0; exc = 13'h008; fr = 0; fi = 0; fprf = 5'h01; done = 1;
    @(negedge clk);
    done = 0; exc = 0; flush = 1;
    @(negedge clk);
    flush = 0;
    check("R13 done then flush status", status, 32'hF700_1110);
    check("R13 done then flush work", work, 32'hF700_1110);
    @(negedge clk);
    op = 3'd0; exc = 13'h004; done = 1; flush = 1;
    @(negedge clk);
    done = 0; flush = 0; exc = 0;
    check("R13 same cycle", status, 32'hF700_1110);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_arith_and_enable();
    t_edge_vs_level();
    t_protected_bits();
    t_setbit_fx();
    t_move_round_cvt();
    t_start_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule